// File: doc/BRIEF.md
# Ordered Clock Stop Controller

This block gates a set of bus clock outputs and one differential reference clock pair in response to a stop request. The stop request is the active-low pin or a configuration stop bit. All logic runs on a fast oversampling clock `clk`. Both source clocks, the bus clock and the reference clock, enter as levels. The block finds their edges, so the gated outputs are registered copies of the sources that can only be held or released at safe points.

Stopping follows a fixed order. The request is sampled on a rising edge of the free-running bus clock. The stoppable bus outputs are then held low from the next falling edge. Only after that is the reference pair parked, on a rising edge of the reference clock: true output high, complement low. If the park-mode bit is set, the pair is tristated instead. Release runs in the reverse order. The reference pair is re-enabled on a rising edge first, and the bus outputs follow on a bus falling edge, so every output restarts with a whole period.

The sequencer has six states:
- `S_RUN`
- `S_DRAIN_BUS`, entered on a bus rise while stop is requested
- `S_PARK_REF`, entered on a bus fall
- `S_PARKED`, entered on a reference rise
- `S_WAKE_REF`, entered on a bus rise once the request is gone
- `S_WAKE_BUS`, entered on a reference rise

It returns to `S_RUN` on a bus fall. Each output of the free-running group, and the reference pair, can be configured to free-run and ignore all stop sources.

Top module: `ordered_clk_stop`

## Requirements
- R1: After reset, `all_parked` is 0 and every output follows its source clock.
- R2: The stop condition is `stop_req_n` low OR `cfg_stop` high. It is acted on only at a rising edge of the bus clock, after a two-stage synchroniser.
- R3: When a stop is taken, the seven bus outputs stop at a falling edge and stay 0. No high pulse is ever shorter than the source high phase (8 `clk` cycles in the bench).
- R4: The reference pair parks only after the bus outputs are held low, and on a reference rising edge. When parked, `ref_p_out`=1 and `ref_n_out`=0.
- R5: `ref_oe` is 0 while the pair is parked and `cfg_park_hiz`=1. Otherwise it is 1.
- R6: A group output whose `cfg_grp_free[i]`=1 keeps toggling regardless of the pin and of `cfg_stop`. With the bit at 0, it stops low like a bus output.
- R7: With `cfg_ref_free`=1, the reference pair keeps toggling and `ref_oe` stays 1 under any stop source.
- R8: On release, the reference pair resumes before the bus outputs. No output pulse after restart is shortened, and the reference high and low phases stay at least 3 `clk` cycles.
- R9: `all_parked` is 1 exactly while the sequencer is in `S_PARKED`, and it tracks the stop condition once settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| bus_clk_in | input | 1 | Free-running bus source clock level |
| ref_clk_in | input | 1 | Reference source clock level |
| stop_req_n | input | 1 | Stop request pin, active low |
| cfg_stop | input | 1 | Register stop bit, active high |
| cfg_grp_free | input | NUM_GRP | Free-run enable per group output |
| cfg_ref_free | input | 1 | Free-run enable for the reference pair |
| cfg_park_hiz | input | 1 | Tristate the pair instead of driving it when parked |
| bus_clk_out | output | NUM_BUS | Always-stoppable bus clocks |
| grp_clk_out | output | NUM_GRP | Selectable bus clocks |
| ref_p_out | output | 1 | Reference true output |
| ref_n_out | output | 1 | Reference complement output |
| ref_oe | output | 1 | Reference pair output enable |
| all_parked | output | 1 | All stoppable outputs parked |

## Verification
The hardest situation to reach from the ports is a stop or release that lands at different phases of the two source clocks. The order and pulse-width rules only bite when the two edges fall close together. The stimulus repeats full stop and release cycles with the request moved by a growing offset each time. Meanwhile a monitor records the cycle of every edge and the shortest high and low phase seen on the outputs. A vector table then covers the combinations of free-run bits, stop sources and park mode while the block is stopped.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
    typedef enum logic [2:0] {
        S_RUN       = 3'd0,
        S_DRAIN_BUS = 3'd1,
        S_PARK_REF  = 3'd2,
        S_PARKED    = 3'd3,
        S_WAKE_REF  = 3'd4,
        S_WAKE_BUS  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/ocs_edge.sv
module ocs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic cur_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= lvl_in;
            prev_q <= cur_q;
        end
    end

    assign lvl  = cur_q;
    assign rise = cur_q & ~prev_q;
    assign fall = ~cur_q & prev_q;
endmodule

// File: rtl/ocs_sync.sv
module ocs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ocs_gate.sv
module ocs_gate #(
    parameter int   W          = 1,
    parameter logic PARK_LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lvl,
    input  logic         en,
    input  logic [W-1:0] free,
    output logic [W-1:0] out
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_out
            assign out[gi] = (en | free[gi]) ? lvl : PARK_LEVEL;
        end
    endgenerate

    // R3 / R8: the enable moves only while the source sits at the park level
    p_gate_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en != $past(en)) |-> ($past(lvl) == PARK_LEVEL));
endmodule

// File: rtl/ocs_seq.sv
module ocs_seq
    import ocs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_cond,
    input  logic bus_rise,
    input  logic bus_fall,
    input  logic ref_rise,
    output logic bus_en,
    output logic ref_en,
    output logic parked
);
    seq_state_t state;
    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:       if (bus_rise && stop_cond)  nxt = S_DRAIN_BUS;
            S_DRAIN_BUS: if (bus_fall)               nxt = S_PARK_REF;
            S_PARK_REF:  if (ref_rise)               nxt = S_PARKED;
            S_PARKED:    if (bus_rise && !stop_cond) nxt = S_WAKE_REF;
            S_WAKE_REF:  if (ref_rise)               nxt = S_WAKE_BUS;
            S_WAKE_BUS:  if (bus_fall)               nxt = S_RUN;
            default:                                 nxt = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_en <= 1'b1;
            ref_en <= 1'b1;
        end else begin
            bus_en <= !(nxt inside {S_PARK_REF, S_PARKED, S_WAKE_REF, S_WAKE_BUS});
            ref_en <= !(nxt inside {S_PARKED, S_WAKE_REF});
        end
    end

    assign parked = (state == S_PARKED);

    p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && bus_rise && stop_cond) |=> (state == S_DRAIN_BUS));
    p_ref_after_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_en) |-> !bus_en);
    p_wake_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> ref_en);
    p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> (!bus_en && !ref_en));
endmodule

// File: rtl/ordered_clk_stop.sv
module ordered_clk_stop #(
    parameter int NUM_BUS     = 7,
    parameter int NUM_GRP     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_clk_in,
    input  logic               ref_clk_in,
    input  logic               stop_req_n,
    input  logic               cfg_stop,
    input  logic [NUM_GRP-1:0] cfg_grp_free,
    input  logic               cfg_ref_free,
    input  logic               cfg_park_hiz,
    output logic [NUM_BUS-1:0] bus_clk_out,
    output logic [NUM_GRP-1:0] grp_clk_out,
    output logic               ref_p_out,
    output logic               ref_n_out,
    output logic               ref_oe,
    output logic               all_parked
);
    localparam logic [NUM_BUS-1:0] BUS_NEVER_FREE = '0;

    logic stop_cond;
    logic bus_lvl, bus_rise, bus_fall;
    logic ref_lvl, ref_rise, ref_fall;
    logic bus_en, ref_en;
    logic ref_true;

    ocs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(~stop_req_n | cfg_stop), .q(stop_cond)
    );

    ocs_edge u_bus_edge (
        .clk(clk), .rst_n(rst_n), .lvl_in(bus_clk_in),
        .lvl(bus_lvl), .rise(bus_rise), .fall(bus_fall)
    );

    ocs_edge u_ref_edge (
        .clk(clk), .rst_n(rst_n), .lvl_in(ref_clk_in),
        .lvl(ref_lvl), .rise(ref_rise), .fall(ref_fall)
    );

    ocs_seq u_seq (
        .clk(clk), .rst_n(rst_n), .stop_cond(stop_cond),
        .bus_rise(bus_rise), .bus_fall(bus_fall), .ref_rise(ref_rise),
        .bus_en(bus_en), .ref_en(ref_en), .parked(all_parked)
    );

    ocs_gate #(.W(NUM_BUS), .PARK_LEVEL(1'b0)) u_bus_gate (
        .clk(clk), .rst_n(rst_n), .lvl(bus_lvl), .en(bus_en),
        .free(BUS_NEVER_FREE), .out(bus_clk_out)
    );

    ocs_gate #(.W(NUM_GRP), .PARK_LEVEL(1'b0)) u_grp_gate (
        .clk(clk), .rst_n(rst_n), .lvl(bus_lvl), .en(bus_en),
        .free(cfg_grp_free), .out(grp_clk_out)
    );

    ocs_gate #(.W(1), .PARK_LEVEL(1'b1)) u_ref_gate (
        .clk(clk), .rst_n(rst_n), .lvl(ref_lvl), .en(ref_en),
        .free(cfg_ref_free), .out(ref_true)
    );

    assign ref_p_out = ref_true;
    assign ref_n_out = ~ref_true;
    assign ref_oe    = ~(~ref_en & ~cfg_ref_free & cfg_park_hiz);

    // R8: an enabled reference output follows its source through falling edges
    p_ref_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_fall && ref_en) |-> (!ref_p_out && ref_n_out));
endmodule

// File: tb/sim_ordered_clk_stop.sv
`timescale 1ns/1ps
module sim_ordered_clk_stop;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk_in = 1'b0;
    logic ref_clk_in = 1'b0;
    logic stop_req_n = 1'b1;
    logic cfg_stop = 1'b0;
    logic [2:0] cfg_grp_free = 3'b000;
    logic cfg_ref_free = 1'b0;
    logic cfg_park_hiz = 1'b0;
    logic [6:0] bus_clk_out;
    logic [2:0] grp_clk_out;
    logic ref_p_out, ref_n_out, ref_oe, all_parked;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ordered_clk_stop u0 (
        .clk(clk), .rst_n(rst_n), .bus_clk_in(bus_clk_in), .ref_clk_in(ref_clk_in),
        .stop_req_n(stop_req_n), .cfg_stop(cfg_stop), .cfg_grp_free(cfg_grp_free),
        .cfg_ref_free(cfg_ref_free), .cfg_park_hiz(cfg_park_hiz),
        .bus_clk_out(bus_clk_out), .grp_clk_out(grp_clk_out), .ref_p_out(ref_p_out),
        .ref_n_out(ref_n_out), .ref_oe(ref_oe), .all_parked(all_parked)
    );

    // source clocks: bus 8/8 cycles, reference 3/3 cycles
    initial forever begin repeat (8) @(negedge clk); bus_clk_in = ~bus_clk_in; end
    initial forever begin repeat (3) @(negedge clk); ref_clk_in = ~ref_clk_in; end

    // edge and pulse-width monitor
    logic prev_bus = 1'b0, prev_ref = 1'b0;
    int last_bus_fall = 0, last_ref_rise = 0;
    int mark = 0, first_ref_fall = 0, first_bus_rise = 0;
    bit width_on = 1'b0, bus_seen = 1'b0, ref_seen = 1'b0;
    int bus_len = 0, ref_len = 0;
    int min_bus_hi = 1000, min_bus_lo = 1000, min_ref_hi = 1000, min_ref_lo = 1000;

    initial forever begin
        @(negedge clk);
        cyc++;
        if (bus_clk_out[0] != prev_bus) begin
            if (prev_bus) last_bus_fall = cyc;
            else if (first_bus_rise == 0 && cyc > mark && mark != 0) first_bus_rise = cyc;
            if (width_on && bus_seen) begin
                if (prev_bus && bus_len < min_bus_hi) min_bus_hi = bus_len;
                if (!prev_bus && bus_len < min_bus_lo) min_bus_lo = bus_len;
            end
            bus_seen = width_on;
            bus_len = 1;
        end else bus_len++;
        if (ref_p_out != prev_ref) begin
            if (!prev_ref) last_ref_rise = cyc;
            else if (first_ref_fall == 0 && cyc > mark && mark != 0) first_ref_fall = cyc;
            if (width_on && ref_seen) begin
                if (prev_ref && ref_len < min_ref_hi) min_ref_hi = ref_len;
                if (!prev_ref && ref_len < min_ref_lo) min_ref_lo = ref_len;
            end
            ref_seen = width_on;
            ref_len = 1;
        end else ref_len++;
        prev_bus = bus_clk_out[0];
        prev_ref = ref_p_out;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // observation window: toggle flags and final levels
    logic [6:0] tg_bus;
    logic [2:0] tg_grp;
    logic tg_ref;
    task automatic observe(input int n);
        logic [6:0] pb;
        logic [2:0] pg;
        logic pr;
        @(negedge clk);
        pb = bus_clk_out; pg = grp_clk_out; pr = ref_p_out;
        tg_bus = '0; tg_grp = '0; tg_ref = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tg_bus |= bus_clk_out ^ pb;
            tg_grp |= grp_clk_out ^ pg;
            tg_ref |= ref_p_out ^ pr;
            pb = bus_clk_out; pg = grp_clk_out; pr = ref_p_out;
        end
    endtask

    task automatic wait_parked(input bit level);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (all_parked == level) break;
        end
    endtask

    // {stop_req_n, cfg_stop, cfg_grp_free[2:0], cfg_ref_free, cfg_park_hiz}
    localparam logic [6:0] VEC [8] = '{
        7'b1_0_000_0_0, 7'b0_0_000_0_0, 7'b1_1_000_0_1, 7'b0_0_101_0_0,
        7'b1_1_010_1_0, 7'b0_1_111_1_1, 7'b1_0_111_1_0, 7'b0_0_000_0_1
    };

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(all_parked == 1'b0, "R1 parked in reset", all_parked, 0);
        rst_n = 1'b1;
        observe(40);
        chk(all_parked == 1'b0, "R1 parked after reset", all_parked, 0);
        chk(tg_bus == 7'h7f, "R1 bus toggling", tg_bus, 7'h7f);
        chk(tg_ref == 1'b1, "R1 ref toggling", tg_ref, 1);

        // directed stop/release at shifted phases
        width_on = 1'b1;
        for (int it = 0; it < 6; it++) begin
            repeat (it * 3 + 1) @(negedge clk);
            stop_req_n = 1'b0;
            wait_parked(1'b1);
            chk(all_parked == 1'b1, "R9 parked reached", all_parked, 1);
            observe(40);
            chk(tg_bus == 7'h00 && bus_clk_out == 7'h00, "R3 bus held low", bus_clk_out, 0);
            chk(ref_p_out == 1'b1 && ref_n_out == 1'b0 && !tg_ref, "R4 ref parked level",
                {ref_p_out, ref_n_out}, 2);
            chk(last_bus_fall < last_ref_rise, "R4 park order", last_ref_rise, last_bus_fall + 1);
            chk(ref_oe == 1'b1, "R5 driven park", ref_oe, 1);
            first_ref_fall = 0; first_bus_rise = 0; mark = cyc;
            stop_req_n = 1'b1;
            repeat (80) @(negedge clk);
            chk(first_ref_fall != 0 && first_bus_rise != 0 && first_ref_fall < first_bus_rise,
                "R8 resume order", first_ref_fall, first_bus_rise);
            chk(all_parked == 1'b0, "R9 released", all_parked, 0);
        end
        width_on = 1'b0;
        chk(min_bus_hi == 8, "R3 bus high width", min_bus_hi, 8);
        chk(min_bus_lo >= 8, "R8 bus low width", min_bus_lo, 8);
        chk(min_ref_hi >= 3, "R8 ref high width", min_ref_hi, 3);
        chk(min_ref_lo >= 3, "R8 ref low width", min_ref_lo, 3);

        // vector table: stop sources (R2), free-run (R6, R7), park mode (R5), status (R9)
        for (int v = 0; v < 8; v++) begin
            bit st;
            @(posedge clk); #2;
            {stop_req_n, cfg_stop, cfg_grp_free, cfg_ref_free, cfg_park_hiz} = VEC[v];
            st = !VEC[v][6] || VEC[v][5];
            repeat (70) @(negedge clk);
            observe(40);
            chk(tg_bus == (st ? 7'h00 : 7'h7f), "R2 bus stop source", tg_bus, st ? 0 : 127);
            for (int g = 0; g < 3; g++)
                chk(tg_grp[g] == (!st || VEC[v][2+g]), "R6 group free-run", tg_grp[g],
                    !st || VEC[v][2+g]);
            chk(tg_ref == (!st || VEC[v][1]), "R7 ref free-run", tg_ref, !st || VEC[v][1]);
            if (st && !VEC[v][1])
                chk(ref_p_out && !ref_n_out, "R4 vector park level", {ref_p_out, ref_n_out}, 2);
            chk(ref_oe == !(st && !VEC[v][1] && VEC[v][0]), "R5 output enable", ref_oe,
                !(st && !VEC[v][1] && VEC[v][0]));
            chk(all_parked == st, "R9 status", all_parked, st);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule